// File: doc/BRIEF.md
# DMA Channel Lifecycle Controller

This block holds the control/status word of a single DMA channel and the state machine that carries the channel through its life: disabled, enabled, running, suspended and stopped. Software writes a command code into the command byte of the word. The current state is reported in a separate byte of the same word. One copy of the block serves the transfer-side channel and another serves the event-side channel; both copies are identical.

An accepted command does not take effect at once. The block loads a quiesce counter from `quiesce_cycles` when it accepts the command. The state byte keeps showing the old state until the counter has run out. A suspend also waits until no transfer is in flight. Transitions between enabled and running follow descriptor activity and happen without delay. An error seen while the channel is running parks it in stopped, and only a reset command brings it out. Moving data is not part of this block.

Top module: `dma_chan_ctl`

## Requirements
- R1: The command is taken from bits 23:16 of `csr_wdata` when `csr_wr` is high. `csr_rdata` returns the state code in bits 15:8. Bits 23:16 of `csr_rdata` hold the code of the accepted command still waiting to take effect, or 0 when none is waiting. All other bits of `csr_rdata` read 0.
- R2: State codes are 0 disabled, 1 enabled, 2 running, 3 suspended and 4 stopped. After the synchronous reset `rst` the state is disabled and no command is pending.
- R3: `accept_desc` is high exactly when the state is enabled or running and no command is pending.
- R4: Reset command (code 9) is accepted in every state, including while another command is pending, and replaces that command. When it takes effect the state becomes disabled and `ring_clr` pulses high for one cycle, in the first cycle that the state byte shows disabled.
- R5: Enable command (code 1) is accepted only from disabled or suspended and leads to enabled. When no command is pending, enabled becomes running on the edge where `desc_avail` is high. Running goes back to enabled on the edge where both `desc_avail` and `inflight` are low.
- R6: Suspend command (code 2) is accepted only from enabled or running. It takes effect only once the quiesce count has run out and `inflight` is low. Until then the state byte holds the old state.
- R7: A command accepted at clock edge E, with `quiesce_cycles` = Q at that edge, leaves the old state visible through edge E+Q. The new state appears at edge E+Q+1, unless a suspend is still waiting on `inflight`.
- R8: These writes have no effect on state, pending command or outputs: any code other than 1, 2 and 9; an enable or suspend in a state that does not accept it; and any non-reset command while a command is pending.
- R9: An `err_evt` while running moves the channel to stopped on the next edge and cancels a pending suspend. A pending or simultaneous reset command takes priority over the error. `err_evt` has no effect in any other state. Stopped is left only through a reset command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | Write strobe for the control/status word |
| csr_wdata | input | 32 | Write data; command code in bits 23:16 |
| csr_rdata | output | 32 | Read data; pending command in 23:16, state in 15:8 |
| quiesce_cycles | input | CNT_W | Quiesce delay sampled when a command is accepted |
| desc_avail | input | 1 | Descriptors are waiting to be processed |
| inflight | input | 1 | At least one transfer is still in flight |
| err_evt | input | 1 | Channel error indication |
| accept_desc | output | 1 | Channel may take new descriptors |
| ring_clr | output | 1 | One-cycle pulse: ring pointers return to zero |

## Verification
On every cycle the assertions check the following: the state code stays legal and the unused bits read zero; `accept_desc` is never high outside enabled or running; `ring_clr` only accompanies a reset that has just taken effect; suspended is only ever entered with nothing in flight; running is only entered from enabled with descriptors waiting; stopped is left only to disabled; and an error while running leads to stopped. The exact quiesce timing, with the old state visible through E+Q and the new one at E+Q+1, can only be shown by the bench's scenarios. The same holds for the full command-versus-state acceptance table, the reset that overrides a pending command, and the writes that must have no effect.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  localparam int FIELD_W = 8;
  localparam int ST_LSB  = 8;
  localparam int CMD_LSB = 16;

  typedef enum logic [2:0] {
    ST_DIS  = 3'd0,
    ST_EN   = 3'd1,
    ST_RUN  = 3'd2,
    ST_SUS  = 3'd3,
    ST_STOP = 3'd4
  } ch_state_t;

  localparam logic [FIELD_W-1:0] CMD_NONE    = 8'd0;
  localparam logic [FIELD_W-1:0] CMD_ENABLE  = 8'd1;
  localparam logic [FIELD_W-1:0] CMD_SUSPEND = 8'd2;
  localparam logic [FIELD_W-1:0] CMD_RESET   = 8'd9;

  function automatic logic is_operational(input ch_state_t s);
    return (s == ST_EN) || (s == ST_RUN);
  endfunction
endpackage

// File: rtl/dmach_cmd_decode.sv
module dmach_cmd_decode
  import dmach_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 wr,
  input  logic [DATA_W-1:0]    wdata,
  input  ch_state_t            cur_state,
  input  logic                 busy,
  output logic                 accept,
  output logic [FIELD_W-1:0]   acc_code
);
  logic [FIELD_W-1:0] code;
  logic               allowed;

  assign code = wdata[CMD_LSB +: FIELD_W];

  always_comb begin
    allowed = 1'b0;
    unique case (code)
      CMD_RESET:   allowed = 1'b1;
      CMD_ENABLE:  allowed = !busy && ((cur_state == ST_DIS) || (cur_state == ST_SUS));
      CMD_SUSPEND: allowed = !busy && is_operational(cur_state);
      default:     allowed = 1'b0;
    endcase
  end

  assign accept   = wr && allowed;
  assign acc_code = code;
endmodule

// File: rtl/dmach_quiesce_timer.sv
module dmach_quiesce_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/dmach_state_fsm.sv
module dmach_state_fsm
  import dmach_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               accept,
  input  logic [FIELD_W-1:0] acc_code,
  input  logic               timer_expired,
  input  logic               desc_avail,
  input  logic               inflight,
  input  logic               err_evt,
  output ch_state_t          state,
  output logic               busy,
  output logic [FIELD_W-1:0] pend_code,
  output logic               ring_clr
);
  logic acc_reset;
  logic err_hit;
  logic commit;
  ch_state_t target;

  assign acc_reset = accept && (acc_code == CMD_RESET);
  assign err_hit   = err_evt && (state == ST_RUN) && !(busy && pend_code == CMD_RESET);
  assign commit    = busy && timer_expired &&
                     ((pend_code != CMD_SUSPEND) || !inflight);

  always_comb begin
    unique case (pend_code)
      CMD_ENABLE:  target = ST_EN;
      CMD_SUSPEND: target = ST_SUS;
      default:     target = ST_DIS;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_DIS;
      busy      <= 1'b0;
      pend_code <= CMD_NONE;
      ring_clr  <= 1'b0;
    end else begin
      ring_clr <= 1'b0;
      if (acc_reset) begin
        busy      <= 1'b1;
        pend_code <= CMD_RESET;
      end else if (err_hit) begin
        state     <= ST_STOP;
        busy      <= 1'b0;
        pend_code <= CMD_NONE;
      end else if (accept) begin
        busy      <= 1'b1;
        pend_code <= acc_code;
      end else if (commit) begin
        state     <= target;
        busy      <= 1'b0;
        pend_code <= CMD_NONE;
        ring_clr  <= (pend_code == CMD_RESET);
      end else if (!busy) begin
        if ((state == ST_EN) && desc_avail) begin
          state <= ST_RUN;
        end else if ((state == ST_RUN) && !desc_avail && !inflight) begin
          state <= ST_EN;
        end
      end
    end
  end
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dmach_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_wr,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic [DATA_W-1:0] csr_rdata,
  input  logic [CNT_W-1:0]  quiesce_cycles,
  input  logic              desc_avail,
  input  logic              inflight,
  input  logic              err_evt,
  output logic              accept_desc,
  output logic              ring_clr
);
  localparam int ST_PAD = FIELD_W - $bits(ch_state_t);

  ch_state_t          state;
  logic               busy;
  logic               accept;
  logic [FIELD_W-1:0] acc_code;
  logic [FIELD_W-1:0] pend_code;
  logic               expired;

  dmach_cmd_decode #(.DATA_W(DATA_W)) u_dec (
    .wr        (csr_wr),
    .wdata     (csr_wdata),
    .cur_state (state),
    .busy      (busy),
    .accept    (accept),
    .acc_code  (acc_code)
  );

  dmach_quiesce_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (quiesce_cycles),
    .expired  (expired)
  );

  dmach_state_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .accept        (accept),
    .acc_code      (acc_code),
    .timer_expired (expired),
    .desc_avail    (desc_avail),
    .inflight      (inflight),
    .err_evt       (err_evt),
    .state         (state),
    .busy          (busy),
    .pend_code     (pend_code),
    .ring_clr      (ring_clr)
  );

  always_comb begin
    csr_rdata = '0;
    csr_rdata[ST_LSB +: FIELD_W]  = {{ST_PAD{1'b0}}, state};
    csr_rdata[CMD_LSB +: FIELD_W] = pend_code;
  end

  assign accept_desc = is_operational(state) && !busy;
endmodule

// File: rtl/dma_chan_ctl_chk.sv
module dma_chan_ctl_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              csr_wr,
  input logic [DATA_W-1:0] csr_wdata,
  input logic [DATA_W-1:0] csr_rdata,
  input logic              desc_avail,
  input logic              inflight,
  input logic              err_evt,
  input logic              accept_desc,
  input logic              ring_clr
);
  logic [7:0] st;
  logic [7:0] pend;
  logic       wr_reset;
  assign st       = csr_rdata[15:8];
  assign pend     = csr_rdata[23:16];
  assign wr_reset = csr_wr && (csr_wdata[23:16] == 8'd9);

  p_state_legal_r2: assert property (@(posedge clk) disable iff (rst)
    (st <= 8'd4) && (csr_rdata[7:0] == 8'd0) && (csr_rdata[DATA_W-1:24] == '0));

  p_accept_states_r3: assert property (@(posedge clk) disable iff (rst)
    accept_desc |-> ((st == 8'd1) || (st == 8'd2)) && (pend == 8'd0));

  p_ring_clr_r4: assert property (@(posedge clk) disable iff (rst)
    ring_clr |-> (st == 8'd0) && ($past(pend) == 8'd9));

  p_run_entry_r5: assert property (@(posedge clk) disable iff (rst)
    ((st == 8'd2) && ($past(st) != 8'd2)) |-> ($past(st) == 8'd1) && $past(desc_avail));

  p_suspend_idle_r6: assert property (@(posedge clk) disable iff (rst)
    ((st == 8'd3) && ($past(st) != 8'd3)) |-> !$past(inflight));

  p_stop_exit_r9: assert property (@(posedge clk) disable iff (rst)
    (($past(st) == 8'd4) && (st != 8'd4)) |-> (st == 8'd0));

  p_err_stop_r9: assert property (@(posedge clk) disable iff (rst)
    ((st == 8'd2) && err_evt && (pend != 8'd9) && !wr_reset) |=> (st == 8'd4));
endmodule

bind dma_chan_ctl dma_chan_ctl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .csr_wr      (csr_wr),
  .csr_wdata   (csr_wdata),
  .csr_rdata   (csr_rdata),
  .desc_avail  (desc_avail),
  .inflight    (inflight),
  .err_evt     (err_evt),
  .accept_desc (accept_desc),
  .ring_clr    (ring_clr)
);

// File: tb/dma_chan_ctl_test.sv
`timescale 1ns/1ps
module dma_chan_ctl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_wr = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic [7:0]  quiesce_cycles = '0;
  logic        desc_avail = 1'b0;
  logic        inflight = 1'b0;
  logic        err_evt = 1'b0;
  logic        accept_desc;
  logic        ring_clr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  dma_chan_ctl uut (
    .clk(clk), .rst(rst), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .quiesce_cycles(quiesce_cycles),
    .desc_avail(desc_avail), .inflight(inflight), .err_evt(err_evt),
    .accept_desc(accept_desc), .ring_clr(ring_clr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int st_of();
    return int'(csr_rdata[15:8]);
  endfunction

  // one posedge with the write strobe high; returns at the following negedge
  task automatic issue(input int code, input int q);
    @(negedge clk);
    csr_wr = 1'b1;
    csr_wdata = {8'h00, 8'(code), 16'h0000};
    quiesce_cycles = 8'(q);
    @(negedge clk);
    csr_wr = 1'b0;
    csr_wdata = '0;
  endtask

  task automatic go_state(input int s);
    desc_avail = 1'b0; inflight = 1'b0; err_evt = 1'b0;
    issue(9, 0); @(negedge clk);
    if (s == 0) return;
    if (s == 3) begin issue(1, 0); @(negedge clk); issue(2, 0); @(negedge clk); return; end
    issue(1, 0); @(negedge clk);
    if (s == 1) return;
    desc_avail = 1'b1; @(negedge clk);
    if (s == 2) return;
    err_evt = 1'b1; @(negedge clk); err_evt = 1'b0;
  endtask

  function automatic int exp_next(input int s, input int c);
    if (c == 9) return 0;
    if (c == 1 && (s == 0 || s == 3)) return 1;
    if (c == 2 && (s == 1 || s == 2)) return 3;
    return s;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R2: reset state
    chk("R2 reset rdata", int'(csr_rdata), 0);
    chk("R3 reset accept_desc", int'(accept_desc), 0);
    chk("R4 reset ring_clr", int'(ring_clr), 0);

    // R7 R8 R5 R6 R4 R9: sweep of state x command x quiesce
    for (int s = 0; s < 5; s++) begin
      for (int c = 0; c < 17; c++) begin
        for (int qi = 0; qi < 2; qi++) begin
          int code;
          int q;
          int e;
          code = (c == 16) ? 255 : c;
          q = qi * 2;
          go_state(s);
          chk("R2 setup state", st_of(), s);
          issue(code, q);
          repeat (q) @(negedge clk);
          chk("R7 old state held", st_of(), s);
          @(negedge clk);
          e = exp_next(s, code);
          if (e == s) chk("R8 ignored command", st_of(), e);
          else        chk("R7 new state at E+Q+1", st_of(), e);
          chk("R1 no pending after commit", int'(csr_rdata[23:16]), 0);
          desc_avail = 1'b0;
        end
      end
    end

    // R1: pending code readback, R8: non-reset ignored while pending
    go_state(0);
    issue(1, 5);
    chk("R1 pending field", int'(csr_rdata[23:16]), 1);
    chk("R1 state field", int'(csr_rdata[15:8]), 0);
    issue(2, 0);
    chk("R8 pending kept", int'(csr_rdata[23:16]), 1);
    repeat (8) @(negedge clk);
    chk("R8 enable committed despite suspend", st_of(), 1);
    chk("R3 accept in enabled", int'(accept_desc), 1);

    // R5: running follows descriptors
    desc_avail = 1'b1; @(negedge clk);
    chk("R5 enabled to running", st_of(), 2);
    desc_avail = 1'b0; inflight = 1'b1; @(negedge clk);
    chk("R5 running held by inflight", st_of(), 2);
    inflight = 1'b0; @(negedge clk);
    chk("R5 running to enabled", st_of(), 1);

    // R6: suspend waits for inflight; accept_desc drops at acceptance
    go_state(2);
    inflight = 1'b1;
    issue(2, 1);
    chk("R3 accept low while pending", int'(accept_desc), 0);
    repeat (6) @(negedge clk);
    chk("R6 suspend waits inflight", st_of(), 2);
    inflight = 1'b0; @(negedge clk);
    chk("R6 suspended after inflight clears", st_of(), 3);
    chk("R3 accept in suspended", int'(accept_desc), 0);

    // R4: reset overrides pending suspend, ring_clr pulse timing
    go_state(2);
    inflight = 1'b1;
    issue(2, 3);
    issue(9, 0);
    chk("R1 pending replaced by reset", int'(csr_rdata[23:16]), 9);
    chk("R4 no early ring_clr", int'(ring_clr), 0);
    @(negedge clk);
    chk("R4 reset over pending", st_of(), 0);
    chk("R4 ring_clr pulse", int'(ring_clr), 1);
    @(negedge clk);
    chk("R4 ring_clr one cycle", int'(ring_clr), 0);
    inflight = 1'b0;

    // R9: error cancels pending suspend; ignored when enabled
    go_state(2);
    inflight = 1'b1;
    issue(2, 4);
    err_evt = 1'b1; @(negedge clk); err_evt = 1'b0;
    chk("R9 error to stopped", st_of(), 4);
    chk("R9 suspend cancelled", int'(csr_rdata[23:16]), 0);
    inflight = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 stays stopped", st_of(), 4);
    go_state(1);
    err_evt = 1'b1; @(negedge clk); err_evt = 1'b0;
    chk("R9 error ignored in enabled", st_of(), 1);
    go_state(3);
    err_evt = 1'b1; @(negedge clk); err_evt = 1'b0;
    chk("R9 error ignored in suspended", st_of(), 3);

    // R9: pending reset wins over error
    go_state(2);
    issue(9, 2);
    err_evt = 1'b1; @(negedge clk); err_evt = 1'b0;
    chk("R9 reset pending beats error", st_of(), 2);
    repeat (2) @(negedge clk);
    chk("R9 reset commits", st_of(), 0);
    desc_avail = 1'b0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule